// File: doc/BRIEF.md
# EEPROM Programming Controller with Timed Write Unlock

This block sits between a small register bus and an on-chip EEPROM byte array, which is modelled here as a register file. Software loads a target address and a data byte, selects an operation kind, and launches programming with a two-access unlock. The first access arms a short-lived master enable. The second access, made while that enable is still armed, sets the write strobe. The selected operation then runs for a fixed number of clock cycles, set by parameters. During that time the write strobe reads back as one. When the time runs out, hardware clears the strobe and the array byte is updated in the same cycle.

Three operation kinds exist. Erase-then-program stores the data byte. Erase alone forces the byte to all ones. Program alone can only clear bits, so the stored byte becomes the old value ANDed with the data. The combined kind takes the long duration and the other two take the short one. A launch is refused in four cases: the master enable has lapsed, the block is already busy, the flash self-programming engine reports busy, or the reserved kind is selected. A level-type ready interrupt stays high while the block is idle, provided software has enabled it and the global interrupt enable input is high. A synchronous soft reset models a CPU-side reset. It returns the registers to their reset values but does not stop an operation that is already running, and it keeps the operation kind while that operation runs.

Top module: `eeprom_prog_ctrl`

## Requirements
- R1: The master enable (control bit 2) reads back as one for exactly four clock cycles after the write that set it. It then clears itself.
- R2: A control write with bit 1 set starts an operation only if the master enable is still set. Otherwise the write has no effect: bit 1 stays zero and the array is unchanged.
- R3: The master enable is armed only by a control write with bit 2 = 1 and bit 1 = 0. A write with both bits set leaves both bits at zero when the block is idle and unarmed.
- R4: The operation kind is held in control bits 5:4. Code 00 stores the data byte. Code 01 sets the byte to 0xFF. Code 10 stores the old byte ANDed with the data byte.
- R5: After an accepted start, control bit 1 stays one for LONG_CYC cycles in kind 00 and SHORT_CYC cycles in kinds 01 and 10. It then clears, and the array byte is updated in the same cycle.
- R6: While an operation runs, writes to control bits 5:4 are ignored.
- R7: A soft reset clears the operation kind to 00 only if no operation is running. A running operation still completes and updates the array.
- R8: rdy_irq equals the interrupt enable (control bit 3) AND gie AND NOT busy.
- R9: No operation starts while flash_busy is high.
- R10: A start with kind 11 is ignored. A start while busy is ignored and does not change the running operation's length or target.
- R11: After reset, the address, data and control registers read 0, rdy_irq is low and every array byte reads 0xFF.
- R12: Register offsets are 0 for address, 1 for data, 2 for control and 3 for a read-only view of the array byte at the address register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous CPU-side reset, active high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| gie | input | 1 | Global interrupt enable |
| flash_busy | input | 1 | Flash self-programming in progress |
| rdy_irq | output | 1 | Ready interrupt, level |

## Verification
The hardest situations to reach are the edges of the four-cycle unlock window and the launch attempts that land inside a running operation. The bench sweeps the gap between the arming write and the launching write across every value from one to six cycles and across all four operation codes. It then places a soft reset, a re-arm and a second launch inside a running operation, and measures the busy interval at the ports to confirm that neither changed.

// File: rtl/eeprom_prog_pkg.sv
package eeprom_prog_pkg;

  typedef enum logic [1:0] {
    OP_ERASE_WRITE = 2'b00,
    OP_ERASE       = 2'b01,
    OP_WRITE       = 2'b10,
    OP_RSVD        = 2'b11
  } eep_op_e;

  localparam logic [1:0] REG_ADDR = 2'd0;
  localparam logic [1:0] REG_DATA = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_PEEK = 2'd3;

  localparam int unsigned CTL_START = 1;
  localparam int unsigned CTL_ARM   = 2;
  localparam int unsigned CTL_IE    = 3;
  localparam int unsigned CTL_OP_LO = 4;
  localparam int unsigned CTL_OP_HI = 5;

  function automatic logic [7:0] apply_op(eep_op_e op, logic [7:0] old_b, logic [7:0] new_b);
    logic [7:0] r;
    case (op)
      OP_ERASE_WRITE: r = new_b;
      OP_ERASE:       r = 8'hFF;
      OP_WRITE:       r = old_b & new_b;
      default:        r = old_b;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/eep_rst_sync.sv
module eep_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/eep_unlock.sv
module eep_unlock #(
  parameter int unsigned WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic arm,
  output logic armed
);
  localparam int unsigned CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] WIN_L = CW'(WIN);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (clr)               cnt_n = '0;
    else if (arm)          cnt_n = WIN_L;
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign armed = (cnt_q != '0);
endmodule

// File: rtl/eep_busy_timer.sv
module eep_busy_timer
  import eeprom_prog_pkg::*;
#(
  parameter int unsigned LONG_CYC  = 34,
  parameter int unsigned SHORT_CYC = 18
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  eep_op_e op,
  output logic    busy,
  output logic    done
);
  localparam int unsigned MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LONG_L  = CW'(LONG_CYC);
  localparam logic [CW-1:0] SHORT_L = CW'(SHORT_CYC);

  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start)              cnt_n = (op == OP_ERASE_WRITE) ? LONG_L : SHORT_L;
    else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eeprom_prog_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [AW-1:0] commit_addr,
  input  eep_op_e       commit_op,
  input  logic [7:0]    commit_data,
  input  logic [AW-1:0] peek_addr,
  output logic [7:0]    peek_data
);
  logic [DEPTH-1:0][7:0] words;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [7:0] byte_q, byte_n;
    logic       hit;

    assign hit = commit && (commit_addr == AW'(g));

    always_comb begin
      byte_n = byte_q;
      if (hit) byte_n = apply_op(commit_op, byte_q, commit_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   byte_q <= 8'hFF;
      else if (hit) byte_q <= byte_n;
    end

    assign words[g] = byte_q;
  end

  assign peek_data = words[peek_addr];
endmodule

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl
  import eeprom_prog_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned LONG_CYC   = 34,
  parameter int unsigned SHORT_CYC  = 18,
  parameter int unsigned UNLOCK_WIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       bus_we,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       gie,
  input  logic       flash_busy,
  output logic       rdy_irq
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          rst_q_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [7:0]    data_q, data_n;
  logic          ie_q, ie_n;
  eep_op_e       mode_q, mode_n;
  logic [AW-1:0] lat_addr_q, lat_addr_n;
  logic [7:0]    lat_data_q, lat_data_n;
  eep_op_e       lat_op_q, lat_op_n;

  logic    ctrl_wr, addr_wr, data_wr;
  logic    arm_req, start_req, armed, busy, done;
  eep_op_e wr_op;
  logic [7:0] peek_data;

  eep_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign ctrl_wr = bus_we && (bus_addr == REG_CTRL);
  assign addr_wr = bus_we && (bus_addr == REG_ADDR);
  assign data_wr = bus_we && (bus_addr == REG_DATA);
  assign wr_op   = eep_op_e'(bus_wdata[CTL_OP_HI:CTL_OP_LO]);

  assign arm_req   = ctrl_wr && bus_wdata[CTL_ARM] && !bus_wdata[CTL_START] && !soft_rst;
  assign start_req = ctrl_wr && bus_wdata[CTL_START] && armed && !busy
                     && !flash_busy && (wr_op != OP_RSVD) && !soft_rst;

  eep_unlock #(.WIN(UNLOCK_WIN)) u_unlock (
    .clk   (clk),
    .rst_n (rst_q_n),
    .clr   (soft_rst),
    .arm   (arm_req),
    .armed (armed)
  );

  eep_busy_timer #(.LONG_CYC(LONG_CYC), .SHORT_CYC(SHORT_CYC)) u_timer (
    .clk   (clk),
    .rst_n (rst_q_n),
    .start (start_req),
    .op    (wr_op),
    .busy  (busy),
    .done  (done)
  );

  eep_store #(.DEPTH(DEPTH)) u_store (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .commit      (done),
    .commit_addr (lat_addr_q),
    .commit_op   (lat_op_q),
    .commit_data (lat_data_q),
    .peek_addr   (addr_q),
    .peek_data   (peek_data)
  );

  // Next-state for software-visible registers
  always_comb begin
    addr_n = addr_q;
    data_n = data_q;
    ie_n   = ie_q;
    mode_n = mode_q;
    if (soft_rst) begin
      addr_n = '0;
      data_n = '0;
      ie_n   = 1'b0;
      if (!busy) mode_n = OP_ERASE_WRITE;
    end else begin
      if (addr_wr) addr_n = bus_wdata[AW-1:0];
      if (data_wr) data_n = bus_wdata;
      if (ctrl_wr) begin
        ie_n = bus_wdata[CTL_IE];
        if (!busy) mode_n = wr_op;
      end
    end
  end

  // Next-state for the operation snapshot taken at launch
  always_comb begin
    lat_addr_n = lat_addr_q;
    lat_data_n = lat_data_q;
    lat_op_n   = lat_op_q;
    if (start_req) begin
      lat_addr_n = addr_q;
      lat_data_n = data_q;
      lat_op_n   = wr_op;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q <= '0;
      data_q <= '0;
      ie_q   <= 1'b0;
      mode_q <= OP_ERASE_WRITE;
    end else begin
      addr_q <= addr_n;
      data_q <= data_n;
      ie_q   <= ie_n;
      mode_q <= mode_n;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      lat_addr_q <= '0;
      lat_data_q <= '0;
      lat_op_q   <= OP_ERASE_WRITE;
    end else if (start_req) begin
      lat_addr_q <= lat_addr_n;
      lat_data_q <= lat_data_n;
      lat_op_q   <= lat_op_n;
    end
  end

  always_comb begin
    case (bus_addr)
      REG_ADDR: bus_rdata = 8'(addr_q);
      REG_DATA: bus_rdata = data_q;
      REG_CTRL: bus_rdata = {2'b00, mode_q, ie_q, armed, busy, 1'b0};
      default:  bus_rdata = peek_data;
    endcase
  end

  assign rdy_irq = ie_q && gie && !busy;

endmodule

// File: rtl/eeprom_prog_ctrl_chk.sv
module eeprom_prog_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic       arm_req,
  input logic       armed,
  input logic       busy,
  input logic       flash_busy,
  input logic [1:0] mode,
  input logic       rdy_irq
);
  logic [3:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  run_q <= '0;
    else if (arm_req)            run_q <= 4'd1;
    else if (armed && run_q != 4'hF) run_q <= run_q + 4'd1;
    else if (!armed)             run_q <= '0;
  end

  p_arm_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (run_q <= 4'd4));

  p_start_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed));

  p_mode_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mode));

  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rdy_irq);

  p_flash_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(flash_busy));

  p_no_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mode != 2'b11));

  p_soft_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(soft_rst));

endmodule

bind eeprom_prog_ctrl eeprom_prog_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .soft_rst   (soft_rst),
  .arm_req    (arm_req),
  .armed      (armed),
  .busy       (busy),
  .flash_busy (flash_busy),
  .mode       (mode_q),
  .rdy_irq    (rdy_irq)
);

// File: tb/eeprom_prog_ctrl_tb.sv
module eeprom_prog_ctrl_tb;
  localparam int DEPTH = 4;
  localparam int LONG  = 6;
  localparam int SHORT = 3;

  logic       clk = 1'b0;
  logic       rst_n, soft_rst, bus_we, gie, flash_busy;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       rdy_irq;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  eeprom_prog_ctrl #(.DEPTH(DEPTH), .LONG_CYC(LONG), .SHORT_CYC(SHORT), .UNLOCK_WIN(4)) u_dut (
    .clk (clk), .rst_n (rst_n), .soft_rst (soft_rst),
    .bus_we (bus_we), .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .gie (gie), .flash_busy (flash_busy), .rdy_irq (rdy_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ctl(input logic [1:0] op, input logic ie, input logic arm, input logic st);
    return {2'b00, op, ie, arm, st, 1'b0};
  endfunction

  function automatic logic [7:0] ref_op(input logic [1:0] op, input logic [7:0] old_b, input logic [7:0] d);
    case (op)
      2'b00:   return d;
      2'b01:   return 8'hFF;
      2'b10:   return old_b & d;
      default: return old_b;
    endcase
  endfunction

  task automatic begin_op(input int a, input logic [7:0] d, input logic [1:0] op, input logic ie, input int gap);
    wr(2'd0, 8'(a));
    wr(2'd1, d);
    wr(2'd2, ctl(op, ie, 1'b1, 1'b0));
    if (gap > 1) idle(gap - 1);
    wr(2'd2, ctl(op, ie, 1'b0, 1'b1));
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] c;
    n = 0;
    for (int i = 0; i < 64; i++) begin
      rd(2'd2, c);
      if (!c[1]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic run_op(input int a, input logic [7:0] d, input logic [1:0] op, input int gap);
    logic [7:0] c, p;
    logic started;
    int n;
    begin_op(a, d, op, 1'b0, gap);
    started = (gap <= 4) && (op != 2'b11) && !flash_busy;
    rd(2'd2, c);
    check("R2/R9/R10 launch accepted", {7'd0, c[1]}, {7'd0, started});
    if (started) begin
      wait_idle(n);
      check("R5 busy length", 8'(n), (op == 2'b00) ? 8'(LONG) : 8'(SHORT));
      model[a] = ref_op(op, model[a], d);
    end
    rd(2'd3, p);
    check("R4 R12 array byte", p, model[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] c, p;
    int n;
    rst_n = 1'b0; soft_rst = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    gie = 1'b0; flash_busy = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R11 reset state
    rd(2'd2, c); check("R11 ctrl reset", c, 8'h00);
    rd(2'd0, c); check("R11 addr reset", c, 8'h00);
    rd(2'd1, c); check("R11 data reset", c, 8'h00);
    check("R11 irq reset", {7'd0, rdy_irq}, 8'h00);
    for (int a = 0; a < DEPTH; a++) begin
      wr(2'd0, 8'(a));
      rd(2'd3, p); check("R11 R12 erased byte", p, 8'hFF);
    end

    // R1 self-clearing master enable
    wr(2'd2, ctl(2'b00, 1'b0, 1'b1, 1'b0));
    for (int i = 0; i < 6; i++) begin
      rd(2'd2, c);
      check("R1 arm window", {7'd0, c[2]}, {7'd0, (i < 4)});
      @(negedge clk);
    end

    // R3 combined write does not arm
    wr(2'd2, ctl(2'b00, 1'b0, 1'b1, 1'b1));
    rd(2'd2, c);
    check("R3 both bits set", c[2:1], 2'b00);

    // R2 window sweep over gap and operation
    for (int gap = 1; gap <= 6; gap++)
      for (int op = 0; op < 4; op++)
        run_op((gap + op) % DEPTH, 8'(8'h3C ^ (gap * 17 + op * 5)), 2'(op), gap);

    // R4 sweep over every address, kind and two patterns
    for (int op = 0; op < 4; op++)
      for (int a = 0; a < DEPTH; a++) begin
        run_op(a, 8'hA5 ^ 8'(a), 2'(op), 2);
        run_op(a, 8'h5B, 2'(op), 3);
      end

    // R9 flash busy blocks launch
    flash_busy = 1'b1;
    run_op(1, 8'h12, 2'b00, 1);
    flash_busy = 1'b0;
    run_op(1, 8'h12, 2'b00, 1);

    // R6 kind frozen while busy
    begin_op(2, 8'h77, 2'b00, 1'b0, 1);
    wr(2'd2, ctl(2'b01, 1'b0, 1'b0, 1'b0));
    rd(2'd2, c);
    check("R6 kind held while busy", {6'd0, c[5:4]}, 8'h00);
    wait_idle(n);
    check("R6 busy length unchanged", 8'(n + 1), 8'(LONG));
    model[2] = 8'h77;
    rd(2'd3, p); check("R6 array byte", p, model[2]);

    // R10 launch while busy ignored
    begin_op(3, 8'h81, 2'b00, 1'b0, 1);
    wr(2'd1, 8'h00);
    wr(2'd2, ctl(2'b01, 1'b0, 1'b1, 1'b0));
    wr(2'd2, ctl(2'b01, 1'b0, 1'b0, 1'b1));
    wait_idle(n);
    check("R10 busy length unchanged", 8'(n + 3), 8'(LONG));
    model[3] = 8'h81;
    rd(2'd3, p); check("R10 first target kept", p, model[3]);

    // R7 soft reset during operation
    begin_op(0, 8'hF0, 2'b10, 1'b0, 1);
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    rd(2'd2, c);
    check("R7 kind kept while busy", {6'd0, c[5:4]}, 8'h02);
    check("R7 still busy", {7'd0, c[1]}, 8'h01);
    wait_idle(n);
    check("R7 op completes", 8'(n + 1), 8'(SHORT));
    model[0] = model[0] & 8'hF0;
    rd(2'd0, c); check("R7 addr cleared", c, 8'h00);
    rd(2'd3, p); check("R7 array updated", p, model[0]);
    wr(2'd2, ctl(2'b10, 1'b0, 1'b0, 1'b0));
    soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
    rd(2'd2, c); check("R7 idle kind cleared", c, 8'h00);

    // R8 interrupt combinations
    for (int ie = 0; ie < 2; ie++)
      for (int g = 0; g < 2; g++) begin
        wr(2'd2, ctl(2'b00, 1'(ie), 1'b0, 1'b0));
        gie = 1'(g);
        #1;
        check("R8 irq idle", {7'd0, rdy_irq}, {7'd0, 1'(ie & g)});
      end
    gie = 1'b1;
    begin_op(1, 8'h44, 2'b01, 1'b1, 1);
    #1; check("R8 irq low while busy", {7'd0, rdy_irq}, 8'h00);
    wait_idle(n);
    model[1] = 8'hFF;
    #1; check("R8 irq back when idle", {7'd0, rdy_irq}, 8'h01);

    finish_run();
  end
endmodule